// File: doc/BRIEF.md
# DMA Request Routing Channel with Edge-Gated Forwarding

This block is one channel of a request router that sits between peripherals and a DMA controller. A selector chooses one of up to 128 peripheral request lines and drives the DMA request output from it. In the simplest mode the chosen line passes straight through.

When synchronization is turned on, the channel holds its output low until an edge appears on one of 32 trigger inputs. The polarity field decides which edges count. A qualifying edge opens a window that lets exactly `count+1` acknowledged requests through, and then the window closes again. If another qualifying edge arrives while the window still has requests left, the edge is dropped. A sticky overrun flag is set instead, and it can raise an interrupt.

Separately, event generation emits a one-cycle pulse after every `count+1` acknowledged requests. A single 32-bit configuration register with byte-lane write strobes holds all the settings.

Top module: `dmaReqRouter`

## Requirements
- R1: After reset the configuration word reads 0, and `dmaReq`, `evtOut`, `ovrFlag` and `ovrIrq` are all low. Only the implemented bits can ever read as 1 (mask 0x1FFF037F); every other bit reads 0.
- R2: On a write, only the bytes whose `cfgByteEn` bit is set are updated. The field layout is:
  - request selector in bits 6:0
  - overrun interrupt enable in bit 8
  - event enable in bit 9
  - synchronization enable in bit 16
  - polarity in bits 18:17
  - count in bits 23:19
  - trigger selector in bits 28:24
- R3: A write to the count field is ignored while the stored synchronization enable or the stored event enable is 1. Other fields in the same byte are still written.
- R4: With synchronization disabled, `dmaReq` equals `reqIn[selector]` combinationally.
- R5: With synchronization enabled and no window open, `dmaReq` is low whatever the selected line does.
- R6: A qualifying edge on `syncIn[trigger selector]` opens a window. Polarity 01 means rising edges, 10 means falling edges, 11 means both, and 00 means none. If the input changes before clock edge k, the window is open after clock edge k+2.
- R7: An open window closes after `count+1` forwarded requests. A request counts as forwarded when `dmaAck` is high at a clock edge while `dmaReq` is high.
- R8: A qualifying edge while the window is open sets `ovrFlag` and leaves the window's remaining count unchanged. The flag stays set until `ovrClr` is high at a clock edge. `ovrIrq` is the flag gated by the overrun interrupt enable.
- R9: With event enable set, `evtOut` is high for the one cycle after every `(count+1)`-th forwarded request. With event enable clear, `evtOut` never pulses.
- R10: Edges on trigger inputs other than the selected one have no effect on forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIn | input | NUM_REQ | Peripheral request lines |
| syncIn | input | NUM_SYNC | Asynchronous trigger inputs |
| dmaAck | input | 1 | DMA acknowledge of the current request |
| ovrClr | input | 1 | Write-1 clear of the overrun flag |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgByteEn | input | 4 | Byte-lane enables for the write |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read data |
| dmaReq | output | 1 | Request forwarded to the DMA controller |
| evtOut | output | 1 | One-cycle event after each block of requests |
| ovrFlag | output | 1 | Sticky overrun flag |
| ovrIrq | output | 1 | Overrun interrupt request |

## Verification
Each result has its own latency:
- **Configuration:** writes show on `cfgRdata` one clock after the write strobe.
- **Pass-through:** `dmaReq` follows `reqIn` in the same cycle.
- **Window and overrun:** a trigger change opens the window, or sets the overrun flag, three clock edges after the change, because of two synchronizer stages and one edge-detect stage. The bench checks two edges after the change that nothing has happened yet.
- **Events:** `evtOut` appears one clock after the acknowledging edge.

The bench drives on falling edges and samples at the next falling edge after the due clock. An event monitor samples 1 ns after each rising edge and pops the forwarded-request index at which the driver predicted each event.

// File: rtl/drq_pkg.sv
package drq_pkg;
  // register field positions (decoded by the channel logic)
  localparam int REQ_SEL_LSB  = 0;
  localparam int REQ_SEL_W    = 7;
  localparam int OVR_IE_BIT   = 8;
  localparam int EVT_EN_BIT   = 9;
  localparam int SYNC_EN_BIT  = 16;
  localparam int POL_LSB      = 17;
  localparam int POL_W        = 2;
  localparam int CNT_LSB      = 19;
  localparam int CNT_W        = 5;
  localparam int SYNC_SEL_LSB = 24;
  localparam int SYNC_SEL_W   = 5;
  localparam logic [31:0] CFG_IMPL_MASK = 32'h1FFF_037F;

  typedef struct packed {
    logic [SYNC_SEL_W-1:0] syncSel;
    logic [CNT_W-1:0]      reqCount;
    logic [POL_W-1:0]      edgePol;
    logic                  syncEn;
    logic                  evtEn;
    logic                  ovrIntEn;
    logic [REQ_SEL_W-1:0]  reqSel;
  } cfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic passAll;
    logic windowOpen;
  } strobe_t;
endpackage

// File: rtl/drqCfgReg.sv
module drqCfgReg
  import drq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  byteEn,
  input  logic [31:0] wdata,
  output cfg_t        cfg,
  output logic [31:0] rdata
);
  logic [31:0] regQ;
  logic [31:0] laneWord;
  logic [31:0] nextWord;
  logic        countLock;

  // count may only change while both enables are low
  assign countLock = regQ[SYNC_EN_BIT] | regQ[EVT_EN_BIT];

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign laneWord[b*8 +: 8] = byteEn[b] ? wdata[b*8 +: 8] : regQ[b*8 +: 8];
  end

  always_comb begin
    nextWord = laneWord;
    if (countLock) nextWord[CNT_LSB +: CNT_W] = regQ[CNT_LSB +: CNT_W];
    nextWord = nextWord & CFG_IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     regQ <= '0;
    else if (wrEn) regQ <= nextWord;
  end

  assign rdata        = regQ;
  assign cfg.reqSel   = regQ[REQ_SEL_LSB +: REQ_SEL_W];
  assign cfg.ovrIntEn = regQ[OVR_IE_BIT];
  assign cfg.evtEn    = regQ[EVT_EN_BIT];
  assign cfg.syncEn   = regQ[SYNC_EN_BIT];
  assign cfg.edgePol  = regQ[POL_LSB +: POL_W];
  assign cfg.reqCount = regQ[CNT_LSB +: CNT_W];
  assign cfg.syncSel  = regQ[SYNC_SEL_LSB +: SYNC_SEL_W];
endmodule

// File: rtl/drqDatapath.sv
module drqDatapath
  import drq_pkg::*;
#(
  parameter int NUM_REQ     = 128,
  parameter int NUM_SYNC    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_REQ-1:0]    reqIn,
  input  logic [NUM_SYNC-1:0]   syncIn,
  input  logic [REQ_SEL_W-1:0]  reqSel,
  input  logic [SYNC_SEL_W-1:0] syncSel,
  input  strobe_t               strobe,
  output logic                  syncLvl,
  output logic                  dmaReq
);
  logic                   reqLive;
  logic                   syncRaw;
  logic [SYNC_STAGES-1:0] syncPipe;

  always_comb begin
    reqLive = 1'b0;
    if (int'(reqSel) < NUM_REQ) reqLive = reqIn[reqSel];
    syncRaw = 1'b0;
    if (int'(syncSel) < NUM_SYNC) syncRaw = syncIn[syncSel];
  end

  // resynchronizer for the chosen trigger
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncPipe[0] <= 1'b0;
        else       syncPipe[0] <= syncRaw;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncPipe[s] <= 1'b0;
        else       syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign syncLvl = syncPipe[SYNC_STAGES-1];
  assign dmaReq  = reqLive & (strobe.passAll | strobe.windowOpen);
endmodule

// File: rtl/drqControl.sv
module drqControl
  import drq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [POL_W-1:0] edgePol,
  input  logic             syncEn,
  input  logic             evtEn,
  input  logic             ovrIntEn,
  input  logic             syncLvl,
  input  logic             dmaReq,
  input  logic             dmaAck,
  input  logic             ovrClr,
  output strobe_t          strobe,
  output logic             evtOut,
  output logic             ovrFlag,
  output logic             ovrIrq
);
  logic             syncPrev;
  logic             riseSeen;
  logic             fallSeen;
  logic             syncEdge;
  logic             ackTaken;
  logic             windowOpen;
  logic [CNT_W:0]   remaining;
  logic [CNT_W-1:0] evtCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncLvl;

  assign riseSeen   = syncLvl & ~syncPrev;
  assign fallSeen   = ~syncLvl & syncPrev;
  assign syncEdge   = syncEn & ((edgePol[0] & riseSeen) | (edgePol[1] & fallSeen));
  assign ackTaken   = dmaAck & dmaReq;
  assign windowOpen = (remaining != '0);

  // forwarding window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      remaining <= '0;
    else if (!syncEn)               remaining <= '0;
    else if (syncEdge && !windowOpen) remaining <= {1'b0, reqCount} + 1'b1;
    else if (ackTaken && windowOpen)  remaining <= remaining - 1'b1;
  end

  // sticky overrun: set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovrFlag <= 1'b0;
    else       ovrFlag <= (ovrFlag & ~ovrClr) | (syncEdge & windowOpen);
  end

  // output event every reqCount+1 forwarded requests
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtCnt <= '0;
      evtOut <= 1'b0;
    end else if (!evtEn) begin
      evtCnt <= '0;
      evtOut <= 1'b0;
    end else begin
      evtOut <= 1'b0;
      if (ackTaken) begin
        if (evtCnt == reqCount) begin
          evtCnt <= '0;
          evtOut <= 1'b1;
        end else begin
          evtCnt <= evtCnt + 1'b1;
        end
      end
    end
  end

  assign ovrIrq            = ovrFlag & ovrIntEn;
  assign strobe.passAll    = ~syncEn;
  assign strobe.windowOpen = windowOpen;
endmodule

// File: rtl/dmaReqRouter.sv
module dmaReqRouter
  import drq_pkg::*;
#(
  parameter int NUM_REQ     = 128,
  parameter int NUM_SYNC    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REQ-1:0]  reqIn,
  input  logic [NUM_SYNC-1:0] syncIn,
  input  logic                dmaAck,
  input  logic                ovrClr,
  input  logic                cfgWrEn,
  input  logic [3:0]          cfgByteEn,
  input  logic [31:0]         cfgWdata,
  output logic [31:0]         cfgRdata,
  output logic                dmaReq,
  output logic                evtOut,
  output logic                ovrFlag,
  output logic                ovrIrq
);
  cfg_t    cfgQ;
  strobe_t strobe;
  logic    syncLvl;

  drqCfgReg u_cfg (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .byteEn(cfgByteEn),
    .wdata(cfgWdata), .cfg(cfgQ), .rdata(cfgRdata)
  );

  drqDatapath #(
    .NUM_REQ(NUM_REQ), .NUM_SYNC(NUM_SYNC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .syncIn(syncIn),
    .reqSel(cfgQ.reqSel), .syncSel(cfgQ.syncSel), .strobe(strobe),
    .syncLvl(syncLvl), .dmaReq(dmaReq)
  );

  drqControl u_ctl (
    .clk(clk), .rstN(rstN), .reqCount(cfgQ.reqCount), .edgePol(cfgQ.edgePol),
    .syncEn(cfgQ.syncEn), .evtEn(cfgQ.evtEn), .ovrIntEn(cfgQ.ovrIntEn),
    .syncLvl(syncLvl), .dmaReq(dmaReq), .dmaAck(dmaAck), .ovrClr(ovrClr),
    .strobe(strobe), .evtOut(evtOut), .ovrFlag(ovrFlag), .ovrIrq(ovrIrq)
  );
endmodule

// File: rtl/drqChecker.sv
module drqChecker
  import drq_pkg::*;
#(
  parameter int NUM_REQ = 128
) (
  input logic               clk,
  input logic               rstN,
  input logic               syncEn,
  input logic               evtEn,
  input logic [REQ_SEL_W-1:0] reqSel,
  input logic [CNT_W-1:0]   reqCount,
  input logic [NUM_REQ-1:0] reqIn,
  input logic               dmaReq,
  input logic               evtOut,
  input logic               ovrFlag,
  input logic               ovrClr,
  input logic               cfgWrEn,
  input logic [3:0]         cfgByteEn,
  input logic [31:0]        cfgRdata
);
  // R1
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata & ~CFG_IMPL_MASK) == 32'h0);

  // R3
  count_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgByteEn[2] && (syncEn || evtEn)) |=> $stable(reqCount));

  // R4
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!syncEn && (int'(reqSel) < NUM_REQ)) |-> (dmaReq == reqIn[reqSel]));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !ovrClr) |=> ovrFlag);

  // R8
  ovr_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(syncEn));

  // R9
  evt_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtOut |-> $past(evtEn));
endmodule

bind dmaReqRouter drqChecker #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk(clk), .rstN(rstN), .syncEn(cfgQ.syncEn), .evtEn(cfgQ.evtEn),
  .reqSel(cfgQ.reqSel), .reqCount(cfgQ.reqCount), .reqIn(reqIn),
  .dmaReq(dmaReq), .evtOut(evtOut), .ovrFlag(ovrFlag), .ovrClr(ovrClr),
  .cfgWrEn(cfgWrEn), .cfgByteEn(cfgByteEn), .cfgRdata(cfgRdata)
);

// File: tb/tb_dmaReqRouter.sv
module tb_dmaReqRouter;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] reqIn = '0;
  logic [31:0]  syncIn = '0;
  logic         dmaAck = 1'b0;
  logic         ovrClr = 1'b0;
  logic         cfgWrEn = 1'b0;
  logic [3:0]   cfgByteEn = '0;
  logic [31:0]  cfgWdata = '0;
  logic [31:0]  cfgRdata;
  logic         dmaReq, evtOut, ovrFlag, ovrIrq;

  int nChecks = 0;
  int nFail = 0;
  int fwdCount = 0;
  int evtPeriod = 0;  // 0: no events expected
  int expQ[$];

  always #5 clk = ~clk;

  dmaReqRouter dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .syncIn(syncIn), .dmaAck(dmaAck),
    .ovrClr(ovrClr), .cfgWrEn(cfgWrEn), .cfgByteEn(cfgByteEn), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .dmaReq(dmaReq), .evtOut(evtOut), .ovrFlag(ovrFlag),
    .ovrIrq(ovrIrq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(logic [3:0] be, logic [31:0] d);
    cfgWrEn = 1'b1; cfgByteEn = be; cfgWdata = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0;
  endtask

  // driver: one acknowledge, pushes predicted events
  task automatic ackOne();
    dmaAck = 1'b1;
    if (dmaReq) begin
      fwdCount++;
      if (evtPeriod != 0 && (fwdCount % evtPeriod) == 0) expQ.push_back(fwdCount);
    end
    @(negedge clk);
    dmaAck = 1'b0;
  endtask

  function automatic logic [31:0] mkCfg(int tsel, int cnt, int pol, int se, int ege, int soie, int rsel);
    return (32'(tsel) << 24) | (32'(cnt) << 19) | (32'(pol) << 17) | (32'(se) << 16)
         | (32'(ege) << 9) | (32'(soie) << 8) | 32'(rsel);
  endfunction

  // monitor: event scoreboard (R9)
  always @(posedge clk) begin
    #1;
    if (rstN && evtOut) begin
      if (expQ.size() == 0) check("R9 unexpected event", 32'(fwdCount), 32'hFFFF_FFFF);
      else check("R9 event position", 32'(fwdCount), 32'(expQ.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 cfg reset", cfgRdata, 32'h0);
    check("R1 dmaReq reset", 32'(dmaReq), 0);
    check("R1 evtOut reset", 32'(evtOut), 0);
    check("R1 ovrFlag reset", 32'(ovrFlag), 0);
    check("R1 ovrIrq reset", 32'(ovrIrq), 0);

    writeCfg(4'hF, 32'hFFFF_FFFF);
    check("R1 reserved bits zero", cfgRdata, 32'h1FFF_037F);
    writeCfg(4'hF, 32'h0);
    check("R3 count locked by enables", cfgRdata, 32'h00F8_0000);
    writeCfg(4'hF, 32'h0);
    check("R3 count writable when enables low", cfgRdata, 32'h0);

    // R2 byte lanes
    writeCfg(4'b0001, 32'hFFFF_FF05);
    check("R2 byte0 only", cfgRdata, 32'h0000_0005);
    writeCfg(4'b0010, 32'hFFFF_FF00);
    check("R2 byte1 only", cfgRdata, 32'h0000_0305);
    writeCfg(4'hF, 32'h0000_0005);
    check("R2 full word", cfgRdata, 32'h0000_0005);

    // R4 pass-through
    reqIn[5] = 1'b1; #1;
    check("R4 selected line high", 32'(dmaReq), 1);
    reqIn[5] = 1'b0; reqIn[4] = 1'b1; #1;
    check("R4 other line ignored", 32'(dmaReq), 0);
    reqIn[4] = 1'b0;
    tick(1);

    // R5/R6/R7 rising edge window, count 2 -> 3 requests
    writeCfg(4'hF, mkCfg(3, 2, 1, 1, 0, 0, 5));
    reqIn[5] = 1'b1;
    tick(1);
    check("R5 gated without window", 32'(dmaReq), 0);
    syncIn[2] = 1'b1;
    tick(4);
    check("R10 unselected trigger ignored", 32'(dmaReq), 0);
    syncIn[3] = 1'b1;
    tick(2);
    check("R6 not open two edges after rise", 32'(dmaReq), 0);
    tick(1);
    check("R6 open three edges after rise", 32'(dmaReq), 1);
    ackOne(); ackOne();
    check("R7 still open after 2 of 3", 32'(dmaReq), 1);
    ackOne();
    check("R7 closed after 3", 32'(dmaReq), 0);
    syncIn[3] = 1'b0;
    tick(4);
    check("R6 falling ignored with rising polarity", 32'(dmaReq), 0);

    // R6 falling polarity (byte2 write while locked keeps count)
    writeCfg(4'b0100, mkCfg(0, 2, 2, 1, 0, 0, 0));
    syncIn[3] = 1'b1;
    tick(4);
    check("R6 rising ignored with falling polarity", 32'(dmaReq), 0);
    syncIn[3] = 1'b0;
    tick(3);
    check("R6 falling opens window", 32'(dmaReq), 1);
    ackOne(); ackOne(); ackOne();
    check("R7 falling window closed after 3", 32'(dmaReq), 0);

    // R8 overrun with both edges
    writeCfg(4'b0100, mkCfg(0, 0, 3, 1, 0, 0, 0));
    syncIn[3] = 1'b1;
    tick(3);
    check("R6 both-edge polarity opens", 32'(dmaReq), 1);
    syncIn[3] = 1'b0;
    tick(3);
    check("R8 overrun flag set", 32'(ovrFlag), 1);
    check("R8 irq masked", 32'(ovrIrq), 0);
    ackOne(); ackOne();
    check("R8 window not reloaded (open)", 32'(dmaReq), 1);
    ackOne();
    check("R8 window not reloaded (closed)", 32'(dmaReq), 0);
    check("R8 flag sticky", 32'(ovrFlag), 1);
    writeCfg(4'b0010, mkCfg(0, 0, 0, 0, 0, 1, 0));
    check("R8 irq enabled", 32'(ovrIrq), 1);
    ovrClr = 1'b1;
    tick(1);
    ovrClr = 1'b0;
    check("R8 flag cleared", 32'(ovrFlag), 0);
    check("R8 irq cleared", 32'(ovrIrq), 0);

    // R6 polarity 00: no window
    writeCfg(4'b0100, mkCfg(0, 0, 0, 1, 0, 0, 0));
    syncIn[3] = 1'b1;
    tick(4);
    syncIn[3] = 1'b0;
    tick(4);
    check("R6 polarity none", 32'(dmaReq), 0);

    // R9 events every 2 forwarded requests, pass-through mode
    writeCfg(4'hF, 32'h0);
    writeCfg(4'hF, mkCfg(0, 1, 0, 0, 1, 0, 5));
    check("R9 config", cfgRdata, 32'h0008_0205);
    fwdCount = 0;
    evtPeriod = 2;
    for (int i = 0; i < 5; i++) ackOne();
    tick(2);
    check("R9 all events seen", 32'(expQ.size()), 0);
    check("R9 no lingering event", 32'(evtOut), 0);

    // R9 event enable off: acks give no event
    writeCfg(4'b0010, 32'h0);
    evtPeriod = 0;
    for (int i = 0; i < 3; i++) ackOne();
    tick(2);
    check("R9 disabled no event", 32'(evtOut), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule